// File: doc/BRIEF.md
# Hot-Plug Event Escalation Router

This block sits beside a root port's hot-plug logic and turns slot events into two level-sensitive requests for firmware and for a legacy operating system. There are three single-cycle event inputs: command completed, presence detect changed, and attention button pressed. It raises a system-management interrupt request (SMI) and a system-control interrupt request (SCI). Each escalation path has its own enable bit in a control word. Each path latches its own status bits in a status word. Both words are reached through a small register port. Status bits stay set until software writes a 1 to them. The SMI path does not depend on the native interrupt enables or on the SCI path, so both requests can be active in the same cycle.

Each request output is driven by a two-state machine, `REQ_QUIET` and `REQ_RAISED`. One copy of the machine runs for each path. A machine moves from `REQ_QUIET` to `REQ_RAISED` on the ESCALATE transition, when the next-cycle status level of its path becomes non-zero. It moves from `REQ_RAISED` back to `REQ_QUIET` on the RELEASE transition, when that level returns to zero. In any other case it stays where it is. The machine and the status word load on the same edge, so a request follows its status bits with no extra cycle of delay.

Top module: `hp_escalation_router`

## Requirements
- R1: The control word is at offset 0xD8. Bit 30 is the SCI enable and bit 1 is the SMI enable. Both read back as written. All other bits read 0 and ignore writes.
- R2: While the SMI enable is set, an event pulse sets its status bit at offset 0xDC one cycle later. Command completed sets bit 3, attention button sets bit 2, and presence detect changed sets bit 1.
- R3: The SMI status bits are set whatever the native enables (`native_en`) and the SCI enable hold. While the SMI enable is clear, no event sets them.
- R4: Status bit 30 at 0xDC is set one cycle after an event arrives while both the SCI enable and that event's native enable are set. No other condition sets it. In `native_en`, bit 2 is command completed, bit 1 is attention button and bit 0 is presence detect.
- R5: `smi_req` is high exactly while any of status bits 3..1 is set.
- R6: `sci_req` is high exactly while status bit 30 is set.
- R7: Writing a 1 to a status bit at 0xDC clears it. Writing a 0 leaves it unchanged.
- R8: When an event and a clear of the same status bit land in the same cycle, the bit stays set.
- R9: One event can raise `smi_req` and `sci_req` in the same cycle. Neither path suppresses the other.
- R10: After reset, both words read 0 and both requests are low. Unimplemented status bits and all other offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_cmd_done | input | 1 | Command-completed event pulse |
| ev_presence | input | 1 | Presence-detect-changed event pulse |
| ev_button | input | 1 | Attention-button-pressed event pulse |
| native_en | input | 3 | Per-event native interrupt enables {cmd, button, presence} |
| reg_addr | input | 8 | Register offset |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| smi_req | output | 1 | SMI request level |
| sci_req | output | 1 | SCI request level |

## Verification
The bench builds the block with its default parameters: an 8-bit offset, a 32-bit data word, and the words at 0xD8 and 0xDC. With these values, the real bit positions 30, 3, 2 and 1 are reachable by register accesses, and so are the all-ones write masks that probe the unimplemented bits. Under these settings, the bench drives same-cycle event and clear collisions, and it sweeps every combination of enables that matters for the two paths.

// File: rtl/hp_route_pkg.sv
package hp_route_pkg;
    localparam int SCI_EN_BIT  = 30;
    localparam int SMI_EN_BIT  = 1;
    localparam int SCI_STS_BIT = 30;
    localparam int SMI_STS_LO  = 1;
    localparam int NUM_EVT     = 3;
    localparam int NUM_PATH    = 2;

    typedef enum logic {
        REQ_QUIET  = 1'b0,
        REQ_RAISED = 1'b1
    } req_state_t;
endpackage

// File: rtl/hp_ctrl_reg.sv
module hp_ctrl_reg #(
    parameter int ADDR_W = 8,
    parameter logic [ADDR_W-1:0] OFS = 'hD8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic              smi_wbit,
    input  logic              sci_wbit,
    output logic              smi_en,
    output logic              sci_en
);
    logic hit;
    assign hit = wr && (addr == OFS);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            smi_en <= 1'b0;
            sci_en <= 1'b0;
        end else if (hit) begin
            smi_en <= smi_wbit;
            sci_en <= sci_wbit;
        end
    end
endmodule

// File: rtl/hp_status_reg.sv
module hp_status_reg #(
    parameter int ADDR_W  = 8,
    parameter int NUM_EVT = 3,
    parameter logic [ADDR_W-1:0] OFS = 'hDC
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [NUM_EVT-1:0] smi_clr,
    input  logic               sci_clr,
    input  logic [NUM_EVT-1:0] smi_set,
    input  logic               sci_set,
    output logic [NUM_EVT-1:0] smi_q,
    output logic               sci_q,
    output logic [NUM_EVT-1:0] smi_d,
    output logic               sci_d
);
    logic hit;
    assign hit = wr && (addr == OFS);

    // set has priority over a same-cycle write-one clear
    always_comb begin
        smi_d = smi_q;
        sci_d = sci_q;
        if (hit) begin
            smi_d = smi_d & ~smi_clr;
            sci_d = sci_d & ~sci_clr;
        end
        smi_d = smi_d | smi_set;
        sci_d = sci_d | sci_set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            smi_q <= '0;
            sci_q <= 1'b0;
        end else begin
            smi_q <= smi_d;
            sci_q <= sci_d;
        end
    end
endmodule

// File: rtl/hp_req_fsm.sv
module hp_req_fsm
    import hp_route_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic level_d,
    output logic req
);
    req_state_t state, nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= REQ_QUIET;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            REQ_QUIET:  if (level_d)  nxt = REQ_RAISED;  // ESCALATE
            REQ_RAISED: if (!level_d) nxt = REQ_QUIET;   // RELEASE
            default:    nxt = REQ_QUIET;
        endcase
    end

    always_comb begin
        req = (state == REQ_RAISED);
    end
endmodule

// File: rtl/hp_escalation_router.sv
module hp_escalation_router
    import hp_route_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter logic [ADDR_W-1:0] CTRL_OFS = 'hD8,
    parameter logic [ADDR_W-1:0] STAT_OFS = 'hDC
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_cmd_done,
    input  logic              ev_presence,
    input  logic              ev_button,
    input  logic [2:0]        native_en,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              smi_req,
    output logic              sci_req
);
    localparam int SMI_STS_HI = SMI_STS_LO + NUM_EVT - 1;

    logic               smi_en, sci_en;
    logic [NUM_EVT-1:0] evt_vec, smi_set, smi_q, smi_d;
    logic               sci_set, sci_q, sci_d;
    logic [DATA_W-1:0]  ctrl_word, stat_word;
    logic [NUM_PATH-1:0] lvl_d, req_v;
    logic               unused_wdata;

    assign unused_wdata = ^reg_wdata;

    // event order matches status bits {3,2,1} and native_en {2,1,0}
    assign evt_vec = {ev_cmd_done, ev_button, ev_presence};
    assign smi_set = smi_en ? evt_vec : '0;
    assign sci_set = sci_en && |(evt_vec & native_en);

    hp_ctrl_reg #(.ADDR_W(ADDR_W), .OFS(CTRL_OFS)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (reg_wr),
        .addr     (reg_addr),
        .smi_wbit (reg_wdata[SMI_EN_BIT]),
        .sci_wbit (reg_wdata[SCI_EN_BIT]),
        .smi_en   (smi_en),
        .sci_en   (sci_en)
    );

    hp_status_reg #(.ADDR_W(ADDR_W), .NUM_EVT(NUM_EVT), .OFS(STAT_OFS)) u_stat (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (reg_wr),
        .addr    (reg_addr),
        .smi_clr (reg_wdata[SMI_STS_HI:SMI_STS_LO]),
        .sci_clr (reg_wdata[SCI_STS_BIT]),
        .smi_set (smi_set),
        .sci_set (sci_set),
        .smi_q   (smi_q),
        .sci_q   (sci_q),
        .smi_d   (smi_d),
        .sci_d   (sci_d)
    );

    // path 0 = SMI, path 1 = SCI
    assign lvl_d = {sci_d, |smi_d};

    generate
        for (genvar p = 0; p < NUM_PATH; p++) begin : g_path
            hp_req_fsm u_fsm (
                .clk     (clk),
                .rst_n   (rst_n),
                .level_d (lvl_d[p]),
                .req     (req_v[p])
            );
        end
    endgenerate

    assign smi_req = req_v[0];
    assign sci_req = req_v[1];

    always_comb begin
        ctrl_word = '0;
        ctrl_word[SMI_EN_BIT] = smi_en;
        ctrl_word[SCI_EN_BIT] = sci_en;
        stat_word = '0;
        stat_word[SMI_STS_HI:SMI_STS_LO] = smi_q;
        stat_word[SCI_STS_BIT] = sci_q;
    end

    always_comb begin
        if (reg_addr == CTRL_OFS)      reg_rdata = ctrl_word;
        else if (reg_addr == STAT_OFS) reg_rdata = stat_word;
        else                           reg_rdata = '0;
    end
endmodule

// File: rtl/hp_escalation_router_chk.sv
module hp_escalation_router_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        ev_cmd_done,
    input logic        ev_presence,
    input logic        ev_button,
    input logic [2:0]  native_en,
    input logic [7:0]  reg_addr,
    input logic        reg_wr,
    input logic [31:0] reg_wdata,
    input logic        smi_en,
    input logic        sci_en,
    input logic [31:0] stat_word,
    input logic        smi_req,
    input logic        sci_req
);
    logic [2:0] evt;
    logic       clr3;
    assign evt  = {ev_cmd_done, ev_button, ev_presence};
    assign clr3 = reg_wr && reg_addr == 8'hDC && reg_wdata[3];

    // R2
    cmd_sets_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        smi_en && ev_cmd_done |=> stat_word[3]);

    // R3
    smi_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !smi_en && stat_word[3:1] == 3'b000 |=> stat_word[3:1] == 3'b000);

    // R4
    sci_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sci_en && |(evt & native_en) |=> stat_word[30]);

    // R5
    smi_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        smi_req == |stat_word[3:1]);

    // R6
    sci_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sci_req == stat_word[30]);

    // R7
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stat_word[3] && !clr3 |=> stat_word[3]);

    // R8
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr3 && smi_en && ev_cmd_done |=> stat_word[3]);

    // R10
    unimpl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_word & ~32'h4000_000E) == 32'h0);
endmodule

bind hp_escalation_router hp_escalation_router_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ev_cmd_done (ev_cmd_done),
    .ev_presence (ev_presence),
    .ev_button   (ev_button),
    .native_en   (native_en),
    .reg_addr    (reg_addr),
    .reg_wr      (reg_wr),
    .reg_wdata   (reg_wdata),
    .smi_en      (smi_en),
    .sci_en      (sci_en),
    .stat_word   (stat_word),
    .smi_req     (smi_req),
    .sci_req     (sci_req)
);

// File: tb/hp_escalation_router_tb.sv
module hp_escalation_router_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ev_cmd_done = 1'b0, ev_presence = 1'b0, ev_button = 1'b0;
    logic [2:0]  native_en = 3'b000;
    logic [7:0]  reg_addr = 8'h00;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = 32'h0;
    logic [31:0] reg_rdata;
    logic        smi_req, sci_req;
    int total = 0, bad = 0;

    always #2.5 clk = ~clk;

    hp_escalation_router u_dut (
        .clk(clk), .rst_n(rst_n), .ev_cmd_done(ev_cmd_done),
        .ev_presence(ev_presence), .ev_button(ev_button), .native_en(native_en),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .smi_req(smi_req), .sci_req(sci_req)
    );

    localparam logic [7:0] CTL = 8'hD8, STS = 8'hDC;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one cycle: optional write plus events {cmd,button,presence}
    task automatic step(input logic wr, input logic [7:0] a, input logic [31:0] d,
                        input logic [2:0] ev);
        @(negedge clk);
        reg_wr = wr; reg_addr = a; reg_wdata = d;
        {ev_cmd_done, ev_button, ev_presence} = ev;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = 32'h0;
        {ev_cmd_done, ev_button, ev_presence} = 3'b000;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        reg_addr = a;
        #0.5;
        v = reg_rdata;
    endtask

    task automatic expect_state(input string req, input logic [31:0] sts,
                                input logic smi, input logic sci);
        logic [31:0] v;
        rd(STS, v);
        check(req, v, sts);
        check(req, {31'h0, smi_req}, {31'h0, smi});
        check(req, {31'h0, sci_req}, {31'h0, sci});
    endtask

    task automatic t_reset;
        logic [31:0] v;
        rd(CTL, v); check("R10", v, 32'h0);
        expect_state("R10", 32'h0, 1'b0, 1'b0);
        rd(8'h40, v); check("R10", v, 32'h0);
    endtask

    task automatic t_ctrl;
        logic [31:0] v;
        step(1'b1, CTL, 32'hFFFF_FFFF, 3'b000);
        rd(CTL, v); check("R1", v, 32'h4000_0002);
        step(1'b1, CTL, 32'h0, 3'b000);
        rd(CTL, v); check("R1", v, 32'h0);
    endtask

    task automatic t_smi_map;
        step(1'b1, CTL, 32'h0000_0002, 3'b000);
        step(1'b0, CTL, 32'h0, 3'b100);
        expect_state("R2", 32'h8, 1'b1, 1'b0);
        step(1'b1, STS, 32'h0, 3'b000);
        expect_state("R7", 32'h8, 1'b1, 1'b0);
        step(1'b1, STS, 32'h8, 3'b000);
        expect_state("R7", 32'h0, 1'b0, 1'b0);
        step(1'b0, CTL, 32'h0, 3'b010);
        expect_state("R2", 32'h4, 1'b1, 1'b0);
        step(1'b0, CTL, 32'h0, 3'b001);
        expect_state("R5", 32'h6, 1'b1, 1'b0);
        step(1'b1, STS, 32'h4, 3'b000);
        expect_state("R7", 32'h2, 1'b1, 1'b0);
        step(1'b1, STS, 32'hFFFF_FFFF, 3'b000);
        expect_state("R5", 32'h0, 1'b0, 1'b0);
    endtask

    task automatic t_smi_indep;
        native_en = 3'b000;
        step(1'b1, CTL, 32'h4000_0002, 3'b000);
        step(1'b0, CTL, 32'h0, 3'b100);
        expect_state("R3", 32'h8, 1'b1, 1'b0);
        step(1'b1, STS, 32'hFFFF_FFFF, 3'b000);
        step(1'b1, CTL, 32'h4000_0000, 3'b000);
        step(1'b0, CTL, 32'h0, 3'b111);
        expect_state("R3", 32'h0, 1'b0, 1'b0);
    endtask

    task automatic t_sci;
        native_en = 3'b001;
        step(1'b1, CTL, 32'h4000_0000, 3'b000);
        step(1'b0, CTL, 32'h0, 3'b010);
        expect_state("R4", 32'h0, 1'b0, 1'b0);
        step(1'b0, CTL, 32'h0, 3'b001);
        expect_state("R6", 32'h4000_0000, 1'b0, 1'b1);
        step(1'b1, STS, 32'h4000_0000, 3'b000);
        expect_state("R6", 32'h0, 1'b0, 1'b0);
        native_en = 3'b111;
        step(1'b1, CTL, 32'h0, 3'b000);
        step(1'b0, CTL, 32'h0, 3'b111);
        expect_state("R4", 32'h0, 1'b0, 1'b0);
    endtask

    task automatic t_both;
        native_en = 3'b111;
        step(1'b1, CTL, 32'h4000_0002, 3'b000);
        step(1'b0, CTL, 32'h0, 3'b010);
        expect_state("R9", 32'h4000_0004, 1'b1, 1'b1);
        step(1'b1, STS, 32'h4000_0004, 3'b000);
        expect_state("R9", 32'h0, 1'b0, 1'b0);
    endtask

    task automatic t_race;
        native_en = 3'b100;
        step(1'b0, CTL, 32'h0, 3'b100);
        expect_state("R8", 32'h4000_0008, 1'b1, 1'b1);
        step(1'b1, STS, 32'h4000_0008, 3'b100);
        expect_state("R8", 32'h4000_0008, 1'b1, 1'b1);
        step(1'b1, STS, 32'h4000_0008, 3'b000);
        expect_state("R8", 32'h0, 1'b0, 1'b0);
    endtask

    task automatic t_unimpl;
        logic [31:0] v;
        step(1'b1, 8'h40, 32'hFFFF_FFFF, 3'b000);
        rd(8'h40, v); check("R10", v, 32'h0);
        rd(CTL, v); check("R10", v, 32'h4000_0002);
        step(1'b1, STS, 32'hBFFF_FFF1, 3'b000);
        expect_state("R10", 32'h0, 1'b0, 1'b0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_ctrl();
        t_smi_map();
        t_smi_indep();
        t_sci();
        t_both();
        t_race();
        t_unimpl();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule